// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End

This block is the serial edge of an SPI memory device. A host drives chip select, serial clock and serial data in. The block turns that bit stream into whole bytes for a command decoder that sits behind it, and it shifts reply bytes out on the serial data output. It accepts SPI mode 0 (clock idles low) and mode 3 (clock idles high) without any configuration. Input bits are captured on rising clock edges and output bits change on falling clock edges. A chip-select rising edge produces a one-cycle event that the command logic uses to start a write.

All pins are brought into the system clock domain through `SYNC_STAGES` flip-flops. The serial clock must therefore stay in each level for more than `SYNC_STAGES + 1` system clocks. A hold input lets the host pause a transfer partway through and resume it later without resending anything. The pause starts and ends only at moments when the serial clock is low.

Received bytes leave through a valid-only stream (`rx_valid`/`rx_data`). A serial host cannot be stalled, so this stream has no ready input and the consumer must accept every byte in the cycle it is offered. Reply bytes enter through a valid/ready stream (`tx_valid`/`tx_data`/`tx_ready`). A byte moves on a clock where `tx_ready` is high. If `tx_valid` is low in that cycle, nothing is consumed and the fill byte 0xFF is sent instead.

Top module: `spi_mem_frontend`

## Requirements
- R1: Bits are assembled MSB first. After the 8th rising SCK edge of a byte, `rx_valid` is high for exactly one cycle, with the byte on `rx_data`.
- R2: A falling edge of `cs_n` clears the bit count. Bits of a byte left unfinished when `cs_n` went high are discarded, and the next frame starts a fresh byte.
- R3: `so` presents bit 7 of the current reply byte first. It moves to the next lower bit only on a falling SCK edge that follows a rising edge. In mode 3, the first falling edge of a frame leaves the MSB in place.
- R4: A reply byte is taken (`tx_ready` high for one cycle) on the `cs_n` falling edge and on the first falling SCK edge after every 8th rising edge. If `tx_valid` is low at that moment, the byte 0xFF is shifted out.
- R5: `so_oe` is low whenever the synchronized `cs_n` is high.
- R6: A pause starts only when `hold_n` is low while SCK is low, and ends only when `hold_n` is high while SCK is low. A `hold_n` pulse that begins and ends while SCK is high has no effect.
- R7: While paused, `so_oe` is low and SCK edges and SI values are ignored. After the pause, the byte completes from the bit where it stopped.
- R8: A rising edge of `cs_n` produces a one-cycle `cs_done` pulse.
- R9: Each pin passes through `SYNC_STAGES` flip-flops plus one edge-detect stage. With SCK held for 4 or more clocks per level, outputs follow pin events with a fixed latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out (valid when `so_oe` is high) |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | BYTE_W | Received byte |
| tx_valid | input | 1 | Reply byte available |
| tx_data | input | BYTE_W | Reply byte |
| tx_ready | output | 1 | Reply byte is taken this cycle |
| cs_done | output | 1 | One-cycle pulse after `cs_n` rises |

## Verification
The assertions rely on the host keeping every SCK level for at least two system clocks after synchronization. This makes two rising edges impossible on consecutive cycles. They also rely on `cs_n` staying high for at least two clocks between frames. The stimulus holds each SCK level for four clocks and each `cs_n` level for at least four clocks. All pins change only on the falling system clock edge. Hold requests are placed with SCK settled either low or high for several clocks. This keeps each pause decision unambiguous.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic si;
    logic hold_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync
  import spi_fe_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t pins_in,
  output spi_pins_t pins_sync
);

  spi_pins_t stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= PINS_IDLE;
          else        stage_q[g] <= pins_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= PINS_IDLE;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign pins_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held
);

  logic held_q;

  // Pause state only moves while the serial clock is low; deselect clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (cs_n_s) held_q <= 1'b0;
    else if (!sck_s) held_q <= !hold_n_s;
  end

  assign held = held_q;

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              sample_en,
  input  logic              si_bit,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              at_boundary
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] partial_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      partial_q <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (frame_start) begin
        bit_cnt_q <= '0;
        partial_q <= '0;
      end else if (sample_en) begin
        partial_q <= {partial_q[BYTE_W-3:0], si_bit};
        if (bit_cnt_q == LAST_BIT) begin
          rx_valid  <= 1'b1;
          rx_data   <= {partial_q, si_bit};
          bit_cnt_q <= '0;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign at_boundary = (bit_cnt_q == '0);

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int              BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] FILL_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic              at_boundary,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              so_bit
);

  logic [BYTE_W-1:0] shift_q;
  logic              armed_q;
  logic [BYTE_W-1:0] next_byte;

  assign next_byte = tx_valid ? tx_data : FILL_BYTE;
  assign tx_ready  = frame_start | (fall_en & armed_q & at_boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      armed_q <= 1'b0;
    end else if (frame_start) begin
      shift_q <= next_byte;
      armed_q <= 1'b0;
    end else if (fall_en && armed_q) begin
      shift_q <= at_boundary ? next_byte : {shift_q[BYTE_W-2:0], 1'b0};
      armed_q <= 1'b0;
    end else if (rise_en) begin
      armed_q <= 1'b1;
    end
  end

  assign so_bit = shift_q[BYTE_W-1];

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] FILL_BYTE   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              cs_done
);

  localparam int CNT_W = $clog2(BYTE_W);

  spi_pins_t pins_raw, pins_s;
  logic      cs_n_s, sck_s, si_s, hold_n_s;
  logic      cs_n_p, sck_p;
  logic      held, at_boundary;
  logic      frame_start, frame_end, sck_rise, sck_fall, active;
  logic      sample_en, fall_en, cs_done_q;

  assign pins_raw = '{cs_n: cs_n, sck: sck, si: si, hold_n: hold_n};

  spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_raw), .pins_sync(pins_s)
  );

  assign cs_n_s   = pins_s.cs_n;
  assign sck_s    = pins_s.sck;
  assign si_s     = pins_s.si;
  assign hold_n_s = pins_s.hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_p    <= 1'b1;
      sck_p     <= 1'b0;
      cs_done_q <= 1'b0;
    end else begin
      cs_n_p    <= cs_n_s;
      sck_p     <= sck_s;
      cs_done_q <= frame_end;
    end
  end

  assign frame_start = cs_n_p & ~cs_n_s;
  assign frame_end   = ~cs_n_p & cs_n_s;
  assign sck_rise    = ~sck_p & sck_s;
  assign sck_fall    = sck_p & ~sck_s;
  assign active      = ~cs_n_s & ~held & ~frame_start;
  assign sample_en   = active & sck_rise;
  assign fall_en     = active & sck_fall;

  spi_fe_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s),
    .hold_n_s(hold_n_s), .held(held)
  );

  spi_fe_rx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sample_en(sample_en),
    .si_bit(si_s), .rx_valid(rx_valid), .rx_data(rx_data), .at_boundary(at_boundary)
  );

  spi_fe_tx #(.BYTE_W(BYTE_W), .FILL_BYTE(FILL_BYTE)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rise_en(sample_en),
    .fall_en(fall_en), .at_boundary(at_boundary), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .so_bit(so)
  );

  assign so_oe   = ~cs_n_s & ~held;
  assign cs_done = cs_done_q;

endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_s,
  input logic cs_n_s,
  input logic held,
  input logic rx_valid,
  input logic tx_ready,
  input logic cs_done,
  input logic so_oe
);

  // R1
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  cs_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |=> !cs_done);

  // R4
  tx_take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R7
  held_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> !rx_valid);

  // R6
  hold_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((held != $past(held)) && !$past(cs_n_s)) |-> !$past(sck_s));

  // R5
  oe_off_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |-> !so_oe);

endmodule

bind spi_mem_frontend spi_mem_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .held(held),
  .rx_valid(rx_valid), .tx_ready(tx_ready), .cs_done(cs_done), .so_oe(so_oe)
);

// File: tb/spi_mem_frontend_bench.sv
module spi_mem_frontend_bench;

  localparam int N = 2;
  localparam logic [7:0] FILL = 8'hFF;

  typedef struct packed { logic cs, sck, si, hold; } pin_t;
  localparam pin_t IDLE = '{cs: 1'b1, sck: 1'b0, si: 1'b0, hold: 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic so, so_oe, rx_valid, tx_ready, cs_done;
  logic [7:0] rx_data;

  spi_mem_frontend u_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .cs_done(cs_done)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] rxq[$];
  int done_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  pin_t q[$];
  pin_t ms, mp;
  int   m_cnt;
  logic [7:0] m_sh, m_rxd, m_txsh;
  bit   m_rxv, m_rs, m_held, m_done, cf, cr, rr, ff, act;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < N + 2; i++) q.push_back(IDLE);
      m_cnt = 0; m_sh = 0; m_rxd = 0; m_txsh = 0;
      m_rxv = 0; m_rs = 0; m_held = 0; m_done = 0;
    end else begin
      q.push_front('{cs: cs_n, sck: sck, si: si, hold: hold_n});
      void'(q.pop_back());
      ms = q[N]; mp = q[N+1];
      cf = mp.cs && !ms.cs;  cr = !mp.cs && ms.cs;
      rr = !mp.sck && ms.sck; ff = mp.sck && !ms.sck;
      act = !ms.cs && !m_held && !cf;
      m_rxv = 0; m_done = cr;
      if (cf) begin
        m_cnt = 0; m_sh = 0; m_rs = 0;
        m_txsh = tx_valid ? tx_data : FILL;
      end else if (act && rr) begin
        m_sh = {m_sh[6:0], ms.si};
        if (m_cnt == 7) begin m_rxv = 1; m_rxd = m_sh; m_cnt = 0; end
        else m_cnt++;
        m_rs = 1;
      end else if (act && ff && m_rs) begin
        m_txsh = (m_cnt == 0) ? (tx_valid ? tx_data : FILL) : {m_txsh[6:0], 1'b0};
        m_rs = 0;
      end
      if (ms.cs) m_held = 0;
      else if (!ms.sck) m_held = !ms.hold;
    end
  end

  // Per-clock comparison, away from the active edge
  pin_t na, nb;
  bit   e_oe, e_rdy, e_cf;
  always @(negedge clk) begin
    if (rst_n && q.size() == N + 2) begin
      na = q[N-1]; nb = q[N];
      e_cf  = nb.cs && !na.cs;
      e_oe  = !na.cs && !m_held;
      e_rdy = e_cf || (!na.cs && !m_held && !e_cf && nb.sck && !na.sck && m_rs && m_cnt == 0);
      chk("R5 so_oe", so_oe, e_oe);
      if (e_oe) chk("R3 so", so, m_txsh[7]);
      chk("R9 rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk("R1 rx_data", rx_data, m_rxd);
      chk("R4 tx_ready", tx_ready, e_rdy);
      chk("R8 cs_done", cs_done, m_done);
      if (rx_valid) rxq.push_back(rx_data);
      if (cs_done) done_cnt++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer0(input logic [7:0] b, output logic [7:0] rd);
    for (int i = 7; i >= 0; i--) begin
      si = b[i]; wt(4); rd[i] = so; sck = 1; wt(4); sck = 0;
    end
    wt(4);
  endtask

  task automatic xfer3(input logic [7:0] b, output logic [7:0] rd);
    for (int i = 7; i >= 0; i--) begin
      sck = 0; si = b[i]; wt(4); rd[i] = so; sck = 1; wt(4);
    end
    wt(4);
  endtask

  task automatic pop_rx(input string tag, input logic [7:0] exp);
    if (rxq.size() == 0) chk(tag, 32'hDEAD, exp);
    else chk(tag, rxq.pop_front(), exp);
  endtask

  initial begin
    logic [7:0] rd, rd2;
    int d0;
    wt(3); rst_n = 1; wt(2);
    chk("R5 reset so_oe", so_oe, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R4 reset tx_ready", tx_ready, 0);

    // Mode 0, two bytes
    tx_valid = 1; tx_data = 8'h5A; d0 = done_cnt;
    cs_n = 0; wt(4);
    xfer0(8'hA5, rd); xfer0(8'h3C, rd2);
    cs_n = 1; wt(6);
    pop_rx("R1 mode0 byte0", 8'hA5); pop_rx("R1 mode0 byte1", 8'h3C);
    chk("R3 mode0 out0", rd, 8'h5A); chk("R4 mode0 out1", rd2, 8'h5A);
    chk("R8 one done pulse", done_cnt - d0, 1);
    chk("R5 oe after deselect", so_oe, 0);

    // Mode 3
    sck = 1; wt(4); tx_data = 8'hC3;
    cs_n = 0; wt(4);
    xfer3(8'h96, rd);
    cs_n = 1; wt(6); sck = 0; wt(4);
    pop_rx("R1 mode3 byte", 8'h96); chk("R3 mode3 out", rd, 8'hC3);

    // Fill byte when no reply available
    tx_valid = 0;
    cs_n = 0; wt(4); xfer0(8'h0F, rd); cs_n = 1; wt(6);
    pop_rx("R1 fill frame byte", 8'h0F); chk("R4 fill byte", rd, FILL);

    // Aborted byte then fresh frame
    cs_n = 0; wt(4);
    for (int i = 0; i < 3; i++) begin si = 1; wt(4); sck = 1; wt(4); sck = 0; end
    cs_n = 1; wt(6);
    chk("R2 no byte from partial", rxq.size(), 0);
    cs_n = 0; wt(4); xfer0(8'h81, rd); cs_n = 1; wt(6);
    pop_rx("R2 fresh byte", 8'h81);

    // Pause in the middle of a byte, with SCK and SI activity during it
    tx_valid = 1; tx_data = 8'hE7;
    cs_n = 0; wt(4);
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) begin
        hold_n = 0; wt(5);
        chk("R7 oe off while paused", so_oe, 0);
        si = ~si; sck = 1; wt(4); si = ~si; sck = 0; wt(4);
        chk("R7 no byte while paused", rxq.size(), 0);
        hold_n = 1; wt(5);
        chk("R7 oe back after pause", so_oe, 1);
      end
      si = rd2[0] ^ 1'b0; si = 8'h6B >> i; wt(4); rd[i] = so; sck = 1; wt(4); sck = 0;
    end
    wt(4); cs_n = 1; wt(6);
    pop_rx("R7 resumed byte", 8'h6B); chk("R7 resumed output", rd, 8'hE7);

    // Hold pulse entirely while SCK is high
    cs_n = 0; wt(4);
    for (int i = 7; i >= 0; i--) begin
      si = 8'hD2 >> i; wt(4); rd[i] = so; sck = 1; wt(4);
      if (i == 5) begin
        hold_n = 0; wt(2); hold_n = 1; wt(4);
        chk("R6 oe kept, SCK high pulse", so_oe, 1);
      end
      sck = 0;
    end
    wt(4); cs_n = 1; wt(6);
    pop_rx("R6 byte unaffected", 8'hD2); chk("R6 output unaffected", rd, 8'hE7);

    wt(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule